// File: doc/BRIEF.md
# Three-Wire Synthesizer Control Interface

This block is the control front end of a frequency synthesizer. A host writes a 26-bit programming word over a three-wire serial bus made of a data line, a shift clock and a frame enable. The word accumulates in a shift register while the enable is high. When the enable goes low, the word is captured into a holding register. The captured word is then applied to the live control fields on the next cycle boundary that the programmable divider reports, so the loop is never retuned in the middle of a divider period.

The live word is decoded into the programmable divider ratio, the reference divider select and its division ratio, the charge-pump current code and its value in microamps, and two open-drain switching port drives. A test bit changes the meaning of the two port bits. With the test bit set, they force the charge pump to sink, to source or to switch off, or they route the comparison clock and the halved divider output onto the two ports. The three serial inputs are asynchronous. They are resynchronized to the system clock, and the rising edges of the shift clock are detected in that clock domain.

Two small state machines control the block. The bus receiver has states `BUS_IDLE` and `BUS_SHIFT`. It moves from `BUS_IDLE` to `BUS_SHIFT` when the synchronized enable is high, and back to `BUS_IDLE` when the enable is low. That return is the capture event. The transfer stage has states `XF_EMPTY` and `XF_PENDING`. A capture moves it to `XF_PENDING`. A divider-cycle pulse with no new capture in the same cycle applies the held word and returns it to `XF_EMPTY`.

Top module: `synth_ctl_if`

## Requirements
- R1: After reset the live word is all zero. The outputs then show divider ratio 0, reference ratio 2, current 230 µA, no pump override and both ports off (`port_pull` = 00, high impedance).
- R2: Shift-clock rising edges shift data only while the enable is high. Edges while the enable is low leave the word unchanged.
- R3: The word is sent MSB first. Bit 25 is port bit 1 and bit 24 is port bit 0. Bit 23 is the test bit. Bits 22:21 are the current code. Bits 20:18 are the reference code. Bit 17 is the reference mode, and bits 16:0 are the divider ratio. The output `ref_sel` is {bit 17, bits 20:18}.
- R4: A frame with more than 26 clock edges captures the last 26 bits shifted in.
- R5: A captured word reaches the live outputs only on a `div_cycle` pulse that follows the capture. A pulse with nothing pending changes nothing.
- R6: Current code 00, 01, 10 and 11 gives `cp_ua` of 230, 1000, 115 and 500.
- R7: With the test bit at 0, no pump override is active. With the test bit at 1, port bits 00 force sink, 01 force source and 10 switch the pump off. At most one override is active at any time.
- R8: With the test bit at 1 and port bits 11, `port_pull[1]` follows `comp_tick` and `port_pull[0]` follows `pd_half`. In the three override modes both ports are off.
- R9: With the test bit at 0, `port_pull` equals the two port bits, where 1 means the port sinks current.
- R10: When `ref_sel[3]` is 0, the reference ratio is 2 shifted left by `ref_sel[2:0]` (2 to 256). When `ref_sel[3]` is 1, codes 0 to 7 give 3, 5, 10, 20, 40, 80, 160 and 320.
- R11: If a second capture arrives before the divider pulse, the newer word replaces the pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial data line, asynchronous |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_en | input | 1 | Frame enable; the falling edge captures the word |
| div_cycle | input | 1 | One-cycle pulse at a divider cycle boundary |
| comp_tick | input | 1 | Comparison clock, routed to port 1 in routing mode |
| pd_half | input | 1 | Divider output halved, routed to port 0 in routing mode |
| div_ratio | output | 17 | Live divider ratio |
| ref_sel | output | 4 | Reference mode bit and 3-bit code |
| ref_ratio | output | 9 | Decoded reference division ratio |
| cp_code | output | 2 | Live charge-pump current code |
| cp_ua | output | 10 | Decoded pump current in µA |
| test_en | output | 1 | Live test bit |
| port_bits | output | 2 | Live port bits |
| cp_sink | output | 1 | Forces the pump to sink |
| cp_source | output | 1 | Forces the pump to source |
| cp_off | output | 1 | Switches the pump off |
| port_pull | output | 2 | Open-drain port drives, 1 = sinking |

## Verification
The assertions check the fixed relations on every cycle:
- the override outputs are mutually exclusive and inactive in normal mode;
- the ports mirror the port bits in normal mode and the routed clocks in routing mode;
- the current and reference decodes match their tables;
- the live fields stay still in any cycle without a divider pulse.

Only the bench scenarios can show the sequencing behaviour: that the enable fall captures the right 26 bits, that stray clocks outside a frame and extra leading bits are discarded, and that a later capture replaces a pending word.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;

    localparam int WORD_W   = 26;
    localparam int RATIO_W  = 17;
    localparam int REFSEL_W = 4;
    localparam int REFR_W   = 9;
    localparam int UA_W     = 10;

    // field layout of the serial word, MSB first on the wire
    typedef struct packed {
        logic               prt1;
        logic               prt0;
        logic               tst;
        logic [1:0]         amp;
        logic [2:0]         rcode;
        logic               rmode;
        logic [RATIO_W-1:0] ratio;
    } ctl_word_t;

    typedef enum logic {BUS_IDLE, BUS_SHIFT} bus_state_t;
    typedef enum logic {XF_EMPTY, XF_PENDING} xfer_state_t;

    function automatic logic [UA_W-1:0] pump_ua(input logic [1:0] code);
        logic [UA_W-1:0] v;
        unique case (code)
            2'b00: v = UA_W'(230);
            2'b01: v = UA_W'(1000);
            2'b10: v = UA_W'(115);
            2'b11: v = UA_W'(500);
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic logic [REFR_W-1:0] ref_div(input logic mode, input logic [2:0] code);
        logic [REFR_W-1:0] v;
        if (!mode) begin
            v = REFR_W'(2) << code;
        end else if (code == 3'd0) begin
            v = REFR_W'(3);
        end else begin
            v = REFR_W'(5) << (3'(code - 3'd1));
        end
        return v;
    endfunction

endpackage

// File: rtl/synth_ctl_sync.sv
module synth_ctl_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
        if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[gi] <= '0;
                else        stage_q[gi] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[gi] <= '0;
                else        stage_q[gi] <= stage_q[gi-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/synth_ctl_rx.sv
module synth_ctl_rx
    import synth_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_data,
    input  logic              s_clk,
    input  logic              s_en,
    output logic [WORD_W-1:0] word_o,
    output logic              cap_o
);

    bus_state_t        state_q, state_d;
    logic              prev_clk_q;
    logic [WORD_W-1:0] shreg_q, shreg_d;
    logic              clk_rise;

    assign clk_rise = s_clk & ~prev_clk_q;

    // state register and shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= BUS_IDLE;
            prev_clk_q <= 1'b0;
            shreg_q    <= '0;
        end else begin
            state_q    <= state_d;
            prev_clk_q <= s_clk;
            shreg_q    <= shreg_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        shreg_d = shreg_q;
        cap_o   = 1'b0;
        if (s_en && clk_rise) begin
            shreg_d = {shreg_q[WORD_W-2:0], s_data};
        end
        unique case (state_q)
            BUS_IDLE: begin
                if (s_en) state_d = BUS_SHIFT;
            end
            BUS_SHIFT: begin
                if (!s_en) begin
                    state_d = BUS_IDLE;
                    cap_o   = 1'b1;
                end
            end
            default: state_d = BUS_IDLE;
        endcase
    end

    assign word_o = shreg_q;

endmodule

// File: rtl/synth_ctl_xfer.sv
module synth_ctl_xfer
    import synth_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              div_cycle_i,
    output ctl_word_t         live_o
);

    xfer_state_t       state_q, state_d;
    logic [WORD_W-1:0] hold_q;
    ctl_word_t         live_q;
    logic              apply;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= XF_EMPTY;
            hold_q  <= '0;
            live_q  <= '0;
        end else begin
            state_q <= state_d;
            if (cap_i) hold_q <= word_i;
            if (apply) live_q <= ctl_word_t'(hold_q);
        end
    end

    always_comb begin
        state_d = state_q;
        apply   = 1'b0;
        unique case (state_q)
            XF_EMPTY: begin
                if (cap_i) state_d = XF_PENDING;
            end
            XF_PENDING: begin
                if (div_cycle_i) begin
                    apply = 1'b1;
                    if (!cap_i) state_d = XF_EMPTY;
                end
            end
            default: state_d = XF_EMPTY;
        endcase
    end

    assign live_o = live_q;

endmodule

// File: rtl/synth_ctl_dec.sv
module synth_ctl_dec
    import synth_ctl_pkg::*;
(
    input  ctl_word_t           w,
    input  logic                comp_tick,
    input  logic                pd_half,
    output logic [REFR_W-1:0]   ref_ratio,
    output logic [UA_W-1:0]     cp_ua,
    output logic                cp_sink,
    output logic                cp_source,
    output logic                cp_off,
    output logic [1:0]          port_pull
);

    logic [1:0] pbits;
    assign pbits = {w.prt1, w.prt0};

    always_comb begin
        ref_ratio = ref_div(w.rmode, w.rcode);
        cp_ua     = pump_ua(w.amp);
        cp_sink   = 1'b0;
        cp_source = 1'b0;
        cp_off    = 1'b0;
        port_pull = 2'b00;
        if (!w.tst) begin
            port_pull = pbits;
        end else begin
            unique case (pbits)
                2'b00: cp_sink   = 1'b1;
                2'b01: cp_source = 1'b1;
                2'b10: cp_off    = 1'b1;
                2'b11: port_pull = {comp_tick, pd_half};
                default: port_pull = 2'b00;
            endcase
        end
    end

endmodule

// File: rtl/synth_ctl_if.sv
module synth_ctl_if
    import synth_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_data,
    input  logic                ser_clk,
    input  logic                ser_en,
    input  logic                div_cycle,
    input  logic                comp_tick,
    input  logic                pd_half,
    output logic [RATIO_W-1:0]  div_ratio,
    output logic [REFSEL_W-1:0] ref_sel,
    output logic [REFR_W-1:0]   ref_ratio,
    output logic [1:0]          cp_code,
    output logic [UA_W-1:0]     cp_ua,
    output logic                test_en,
    output logic [1:0]          port_bits,
    output logic                cp_sink,
    output logic                cp_source,
    output logic                cp_off,
    output logic [1:0]          port_pull
);

    localparam int SER_W = 3;

    logic [SER_W-1:0]  ser_sync;
    logic [WORD_W-1:0] rx_word;
    logic              rx_cap;
    ctl_word_t         live;

    synth_ctl_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (SER_W)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ser_en, ser_clk, ser_data}),
        .dout  (ser_sync)
    );

    synth_ctl_rx i_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .s_data (ser_sync[0]),
        .s_clk  (ser_sync[1]),
        .s_en   (ser_sync[2]),
        .word_o (rx_word),
        .cap_o  (rx_cap)
    );

    synth_ctl_xfer i_xfer (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_i       (rx_cap),
        .word_i      (rx_word),
        .div_cycle_i (div_cycle),
        .live_o      (live)
    );

    synth_ctl_dec i_dec (
        .w         (live),
        .comp_tick (comp_tick),
        .pd_half   (pd_half),
        .ref_ratio (ref_ratio),
        .cp_ua     (cp_ua),
        .cp_sink   (cp_sink),
        .cp_source (cp_source),
        .cp_off    (cp_off),
        .port_pull (port_pull)
    );

    assign div_ratio = live.ratio;
    assign ref_sel   = {live.rmode, live.rcode};
    assign cp_code   = live.amp;
    assign test_en   = live.tst;
    assign port_bits = {live.prt1, live.prt0};

endmodule

// File: rtl/synth_ctl_if_chk.sv
module synth_ctl_if_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        div_cycle,
    input logic        comp_tick,
    input logic        pd_half,
    input logic [16:0] div_ratio,
    input logic [3:0]  ref_sel,
    input logic [8:0]  ref_ratio,
    input logic [1:0]  cp_code,
    input logic [9:0]  cp_ua,
    input logic        test_en,
    input logic [1:0]  port_bits,
    input logic        cp_sink,
    input logic        cp_source,
    input logic        cp_off,
    input logic [1:0]  port_pull
);

    a_r7_single_override: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cp_sink, cp_source, cp_off}));

    a_r7_quiet_normal: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |-> !(cp_sink || cp_source || cp_off));

    a_r9_port_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |-> (port_pull == port_bits));

    a_r8_route: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && port_bits == 2'b11) |-> (port_pull == {comp_tick, pd_half}));

    a_r8_ports_off: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && port_bits != 2'b11) |-> (port_pull == 2'b00));

    a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !div_cycle |=> ($stable(div_ratio) && $stable(ref_sel) && $stable(cp_code)
                        && $stable(test_en) && $stable(port_bits)));

    a_r6_top_current: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_code == 2'b01) |-> (cp_ua == 10'd1000));

    a_r6_low_current: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_code == 2'b10) |-> (cp_ua == 10'd115));

    a_r10_binary_ratio: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_sel[3] |-> ($countones(ref_ratio) == 1));

endmodule

bind synth_ctl_if synth_ctl_if_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_cycle (div_cycle),
    .comp_tick (comp_tick),
    .pd_half   (pd_half),
    .div_ratio (div_ratio),
    .ref_sel   (ref_sel),
    .ref_ratio (ref_ratio),
    .cp_code   (cp_code),
    .cp_ua     (cp_ua),
    .test_en   (test_en),
    .port_bits (port_bits),
    .cp_sink   (cp_sink),
    .cp_source (cp_source),
    .cp_off    (cp_off),
    .port_pull (port_pull)
);

// File: tb/test_synth_ctl_if.sv
module test_synth_ctl_if;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sd = 1'b0, sc = 1'b0, se = 1'b0, dcyc = 1'b0, ct = 1'b0, ph = 1'b0;

    logic [16:0] div_ratio;
    logic [3:0]  ref_sel;
    logic [8:0]  ref_ratio;
    logic [1:0]  cp_code;
    logic [9:0]  cp_ua;
    logic        test_en, cp_sink, cp_source, cp_off;
    logic [1:0]  port_bits, port_pull;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    synth_ctl_if i_synth_ctl_if (
        .clk(clk), .rst_n(rst_n), .ser_data(sd), .ser_clk(sc), .ser_en(se),
        .div_cycle(dcyc), .comp_tick(ct), .pd_half(ph),
        .div_ratio(div_ratio), .ref_sel(ref_sel), .ref_ratio(ref_ratio),
        .cp_code(cp_code), .cp_ua(cp_ua), .test_en(test_en), .port_bits(port_bits),
        .cp_sink(cp_sink), .cp_source(cp_source), .cp_off(cp_off), .port_pull(port_pull)
    );

    // routed clocks toggle away from the comparison edge
    always @(posedge clk) begin
        ct <= ~ct;
        if (ct) ph <= ~ph;
    end

    // behavioural reference: inputs seen two cycles late, previous sample one more
    logic [2:0]  hist[$];
    logic [2:0]  cur, prv;
    logic [25:0] m_sr = '0, m_hold = '0, m_act = '0;
    bit          m_pend = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{3'b000, 3'b000, 3'b000};
            m_sr = '0; m_hold = '0; m_act = '0; m_pend = 1'b0;
        end else begin
            hist.push_back({se, sc, sd});
            cur = hist[hist.size()-3];
            prv = hist[hist.size()-4];
            void'(hist.pop_front());
            if (dcyc && m_pend) m_act = m_hold;
            if (prv[2] && !cur[2]) begin
                m_pend = 1'b1;
                m_hold = m_sr;
            end else if (dcyc) begin
                m_pend = 1'b0;
            end
            if (cur[2] && cur[1] && !prv[1]) m_sr = {m_sr[24:0], cur[0]};
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    function automatic int exp_ua(input logic [1:0] c);
        case (c)
            2'b00: return 230;
            2'b01: return 1000;
            2'b10: return 115;
            default: return 500;
        endcase
    endfunction

    function automatic int exp_ref(input logic [3:0] s);
        int odd[8] = '{3, 5, 10, 20, 40, 80, 160, 320};
        if (s[3]) return odd[s[2:0]];
        return 2 ** (s[2:0] + 1);
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [2:0] ov;
            logic [1:0] pp;
            ov = 3'b000;
            pp = m_act[25:24];
            if (m_act[23]) begin
                case (m_act[25:24])
                    2'b00: begin ov = 3'b100; pp = 2'b00; end
                    2'b01: begin ov = 3'b010; pp = 2'b00; end
                    2'b10: begin ov = 3'b001; pp = 2'b00; end
                    default: pp = {ct, ph};
                endcase
            end
            chk("R3 div_ratio", 32'(div_ratio), 32'(m_act[16:0]));
            chk("R3 fields", 32'({ref_sel, cp_code, test_en, port_bits}),
                32'({m_act[17], m_act[20:18], m_act[22:21], m_act[23], m_act[25:24]}));
            chk("R10 ref_ratio", 32'(ref_ratio), 32'(exp_ref({m_act[17], m_act[20:18]})));
            chk("R6 cp_ua", 32'(cp_ua), 32'(exp_ua(m_act[22:21])));
            chk("R7 overrides", 32'({cp_sink, cp_source, cp_off}), 32'(ov));
            chk("R9 R8 port_pull", 32'(port_pull), 32'(pp));
        end
    end

    function automatic logic [25:0] mk(input logic [1:0] p, input logic t,
                                       input logic [1:0] c, input logic [3:0] rs,
                                       input logic [16:0] n);
        return {p, t, c, rs[2:0], rs[3], n};
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [63:0] bits, input int n);
        @(negedge clk); se = 1'b1;
        wait_cyc(3);
        for (int i = n - 1; i >= 0; i--) begin
            sd = bits[i]; wait_cyc(3);
            sc = 1'b1;    wait_cyc(3);
            sc = 1'b0;    wait_cyc(3);
        end
        se = 1'b0; sd = 1'b0;
        wait_cyc(6);
    endtask

    task automatic pulse_div();
        @(negedge clk); dcyc = 1'b1;
        @(negedge clk); dcyc = 1'b0;
        wait_cyc(1);
    endtask

    task automatic load(input logic [25:0] w);
        send(64'(w), 26);
        pulse_div();
        chk("R5 applied word", 32'({port_bits, test_en, cp_code, ref_sel[2:0], ref_sel[3], div_ratio}),
            32'(w));
    endtask

    initial begin
        logic [25:0] w;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(3);
        // R1 reset state
        chk("R1 div_ratio", 32'(div_ratio), 0);
        chk("R1 port_pull", 32'(port_pull), 0);
        chk("R1 overrides", 32'({cp_sink, cp_source, cp_off}), 0);
        chk("R1 cp_ua", 32'(cp_ua), 230);
        chk("R1 ref_ratio", 32'(ref_ratio), 2);

        // R5: capture does not reach outputs until the divider pulse
        w = mk(2'b10, 1'b0, 2'b01, 4'b0011, 17'h1ABCD);
        send(64'(w), 26);
        wait_cyc(10);
        chk("R5 held before pulse", 32'(div_ratio), 0);
        pulse_div();
        chk("R3 ratio after pulse", 32'(div_ratio), 32'h1ABCD);
        chk("R9 port drive", 32'(port_pull), 2);
        chk("R6 current 01", 32'(cp_ua), 1000);
        // R5: pulse with nothing pending
        pulse_div();
        chk("R5 idle pulse", 32'(div_ratio), 32'h1ABCD);

        // R2: stray shift clocks with enable low
        for (int k = 0; k < 5; k++) begin
            sd = 1'b1; wait_cyc(3); sc = 1'b1; wait_cyc(3); sc = 1'b0; wait_cyc(3);
        end
        sd = 1'b0;
        pulse_div();
        chk("R2 no capture without enable", 32'(div_ratio), 32'h1ABCD);
        w = mk(2'b01, 1'b0, 2'b00, 4'b0101, 17'h00F0F);
        load(w);
        chk("R2 clean word after strays", 32'(div_ratio), 32'h00F0F);
        chk("R9 port drive 01", 32'(port_pull), 1);

        // R6 current codes
        for (int c = 0; c < 4; c++) begin
            load(mk(2'b11, 1'b0, 2'(c), 4'b0000, 17'(c * 4099 + 7)));
            chk("R6 current code", 32'(cp_ua), 32'(exp_ua(2'(c))));
        end

        // R10 every reference select
        for (int r = 0; r < 16; r++) begin
            load(mk(2'(r), 1'b0, 2'(r >> 2), 4'(r), 17'(r * 7919)));
            chk("R10 ref ratio", 32'(ref_ratio), 32'(exp_ref(4'(r))));
        end

        // R7 / R8 test overrides
        load(mk(2'b00, 1'b1, 2'b10, 4'b1111, 17'h1FFFF));
        chk("R7 sink", 32'({cp_sink, cp_source, cp_off, port_pull}), 32'(5'b10000));
        load(mk(2'b01, 1'b1, 2'b10, 4'b1111, 17'h00001));
        chk("R7 source", 32'({cp_sink, cp_source, cp_off, port_pull}), 32'(5'b01000));
        load(mk(2'b10, 1'b1, 2'b10, 4'b1111, 17'h10000));
        chk("R7 off", 32'({cp_sink, cp_source, cp_off, port_pull}), 32'(5'b00100));
        load(mk(2'b11, 1'b1, 2'b11, 4'b1000, 17'h0AAAA));
        for (int k = 0; k < 8; k++) begin
            wait_cyc(1);
            chk("R8 routed ports", 32'(port_pull), 32'({ct, ph}));
        end

        // R4 long frame keeps the last 26 bits
        w = mk(2'b01, 1'b0, 2'b11, 4'b0110, 17'h15555);
        send({34'h0, 4'b1011, w}, 30);
        pulse_div();
        chk("R4 long frame", 32'({port_bits, test_en, cp_code, div_ratio}), 32'({2'b01, 1'b0, 2'b11, 17'h15555}));

        // R11 newer capture replaces pending word
        send(64'(mk(2'b10, 1'b0, 2'b00, 4'b0001, 17'h01111)), 26);
        send(64'(mk(2'b00, 1'b0, 2'b01, 4'b1010, 17'h02222)), 26);
        pulse_div();
        chk("R11 newest wins", 32'(div_ratio), 32'h02222);
        chk("R11 newest ports", 32'(port_pull), 0);

        wait_cyc(4);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL R5 watchdog got=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule